// File: doc/BRIEF.md
# Variable-Window Register Stack Controller

This block keeps a 128-entry register stack that procedures take slices of, plus a separate 64-entry bank of global registers that no call or return ever moves. A call request names how many registers the new procedure needs, and the block allocates exactly that many. A return request names the size of the window being released and the size of the caller's window that must be present again. Stack registers are addressed relative to the current window: relative number r reaches physical slot (stack pointer + r) modulo 128. The stack grows downward, so after a call of n registers, the caller's old r0 is the new r(n).

When a call would leave more than 128 registers resident, the block pushes the oldest ones out through a memory port, one word per handshake. When a return leaves fewer resident registers than the caller's window holds, the block pulls the missing words back from memory. While either transfer runs, `busy` is high. Call and return requests wait, and register writes from the core side are dropped. Comparison results and flags have no special register; they go into ordinary registers like any other data.

The controller has three states. IDLE accepts requests. SPILL writes the oldest resident word each time the memory acknowledges. FILL reads a word back each time the memory acknowledges. The transitions are:
- IDLE to SPILL: a valid call leaves more than 128 registers resident.
- SPILL to IDLE: the acknowledge that brings the resident count back to 128.
- IDLE to FILL: a valid return leaves fewer resident registers than the caller size.
- FILL to IDLE: the acknowledge that makes the caller's window resident.
- Every other request leaves the controller in IDLE.

Top module: `regstack_ctrl`

## Requirements
- R1: After reset, `busy`, `op_err` and `mem_req` are 0 and `rd_data` is 0. The stack is empty, so a return of size 1 is rejected.
- R2: The global bank holds 64 words, addressed by the low 6 bits of the index when the global flag is 1. Calls and returns never change what a global index reads.
- R3: A call of size n allocates exactly n registers. Afterwards, relative register r+n reads what register r read before the call.
- R4: A return of size n restores the mapping that was in place before the matching call. The caller's registers read back their earlier values.
- R5: `op_err` goes high for one cycle after any rejected request, and the mapping and memory traffic stay as they were. The rejected requests are:
  - a call of size 0 or above 128;
  - a return of size 0, or larger than the registers resident on chip;
  - a return whose caller size exceeds 128 or exceeds the registers that would still be allocated.
- R6: While more than 128 registers are resident, the oldest words are written to memory one per acknowledge, until 128 remain. A word's address is its depth below the top of the stack: address 0 is the highest-numbered register of the first window ever allocated. No memory write happens while 128 or fewer are resident.
- R7: On return, missing caller words are read back from memory in turn. The read address is one below the current spilled count. The returned data is written into the register that held that word before the spill.
- R8: `busy` is high while a spill or fill runs. `mem_req`, `mem_addr` and `mem_we` hold steady until `mem_ack`. Requests and register writes presented while `busy` is high have no effect.
- R9: Register reads and writes presented in the same cycle as an accepted call or return use the mapping from before it. `rd_data` appears one cycle after the index is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Call or return request present |
| op_ret | input | 1 | 1 = return, 0 = call |
| op_size | input | 8 | Window size allocated or released |
| op_caller | input | 8 | Caller window size to make resident on return |
| busy | output | 1 | Spill or fill in progress |
| op_err | output | 1 | Previous request rejected |
| rd_glob | input | 1 | Read targets the global bank |
| rd_idx | input | 7 | Read index (relative for the stack) |
| rd_data | output | 32 | Registered read data |
| wr_en | input | 1 | Register write enable |
| wr_glob | input | 1 | Write targets the global bank |
| wr_idx | input | 7 | Write index (relative for the stack) |
| wr_data | input | 32 | Write data |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = spill write, 0 = fill read |
| mem_addr | output | 16 | Word address (depth below the stack top) |
| mem_wdata | output | 32 | Spill data |
| mem_ack | input | 1 | Memory completes the transfer this cycle |
| mem_rdata | input | 32 | Fill data, valid with mem_ack |

## Verification
Two things can land in the same cycle: a call being accepted, and a register access through the relative mapping that the call is about to move. The bench presents a call of size 4 together with a write to r0 and a read of r1. The read must return the caller's r1, and the written value must then appear at r4. A second overlap pairs a spill that is running with a new call and a global write. Both must be dropped, which shows as an unchanged spill-write count and global word, and as a later return that restores the original window.

// File: rtl/rstk_pkg.sv
package rstk_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SPILL = 2'd1,
        ST_FILL  = 2'd2
    } rstk_state_e;
endpackage

// File: rtl/rstk_ctrl.sv
module rstk_ctrl
    import rstk_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int AW    = 16,
    localparam int IW   = $clog2(DEPTH),
    localparam int SZW  = $clog2(DEPTH + 1),
    localparam int RW   = $clog2(2 * DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           op_valid,
    input  logic           op_ret,
    input  logic [SZW-1:0] op_size,
    input  logic [SZW-1:0] op_caller,
    input  logic           mem_ack,
    output logic           busy,
    output logic           op_err,
    output logic [IW-1:0]  sp_idx,
    output logic           mem_req,
    output logic           mem_we,
    output logic [AW-1:0]  mem_addr,
    output logic [IW-1:0]  port_idx,
    output logic           fill_wr
);
    rstk_state_e   state_q, state_d;
    logic [IW-1:0] sp_q, sp_d;
    logic [AW-1:0] alloc_q, alloc_d;
    logic [RW-1:0] resid_q, resid_d;
    logic [RW-1:0] need_q, need_d;
    logic          err_q, err_d;

    logic [RW-1:0] size_r, caller_r, resid_up, resid_dn;
    logic [AW:0]   alloc_sum;
    logic [AW-1:0] alloc_left, spilled;
    logic [RW-1:0] spill_pos, fill_pos;
    logic          call_bad, ret_bad, accept;

    always_comb begin
        size_r     = RW'(op_size);
        caller_r   = RW'(op_caller);
        alloc_sum  = {1'b0, alloc_q} + (AW+1)'(op_size);
        alloc_left = alloc_q - AW'(op_size);
        resid_up   = resid_q + size_r;
        resid_dn   = resid_q - size_r;
        call_bad   = (op_size == '0) || (size_r > RW'(DEPTH)) || alloc_sum[AW];
        ret_bad    = (op_size == '0) || (size_r > resid_q) ||
                     (caller_r > RW'(DEPTH)) ||
                     (AW'(op_caller) > alloc_left);
        accept     = op_valid && (state_q == ST_IDLE);
    end

    // next-state and pointer update
    always_comb begin
        state_d = state_q;
        sp_d    = sp_q;
        alloc_d = alloc_q;
        resid_d = resid_q;
        need_d  = need_q;
        err_d   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (accept && !op_ret) begin
                    if (call_bad) begin
                        err_d = 1'b1;
                    end else begin
                        sp_d    = sp_q - IW'(op_size);
                        alloc_d = alloc_sum[AW-1:0];
                        resid_d = resid_up;
                        if (resid_up > RW'(DEPTH)) state_d = ST_SPILL;
                    end
                end else if (accept && op_ret) begin
                    if (ret_bad) begin
                        err_d = 1'b1;
                    end else begin
                        sp_d    = sp_q + IW'(op_size);
                        alloc_d = alloc_left;
                        resid_d = resid_dn;
                        need_d  = caller_r;
                        if (resid_dn < caller_r) state_d = ST_FILL;
                    end
                end
            end
            ST_SPILL: begin
                if (mem_ack) begin
                    resid_d = resid_q - RW'(1);
                    if (resid_q - RW'(1) == RW'(DEPTH)) state_d = ST_IDLE;
                end
            end
            ST_FILL: begin
                if (mem_ack) begin
                    resid_d = resid_q + RW'(1);
                    if (resid_q + RW'(1) >= need_q) state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sp_q    <= '0;
            alloc_q <= '0;
            resid_q <= '0;
            need_q  <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            sp_q    <= sp_d;
            alloc_q <= alloc_d;
            resid_q <= resid_d;
            need_q  <= need_d;
            err_q   <= err_d;
        end
    end

    // outputs
    always_comb begin
        spilled   = alloc_q - AW'(resid_q);
        spill_pos = RW'(sp_q) + resid_q - RW'(1);
        fill_pos  = RW'(sp_q) + resid_q;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        port_idx  = '0;
        fill_wr   = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_SPILL: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = spilled;
                port_idx = spill_pos[IW-1:0];
            end
            ST_FILL: begin
                mem_req  = 1'b1;
                mem_addr = spilled - AW'(1);
                port_idx = fill_pos[IW-1:0];
                fill_wr  = mem_ack;
            end
            default: ;
        endcase
        busy   = (state_q != ST_IDLE);
        op_err = err_q;
        sp_idx = sp_q;
    end

    AST_IDLE_FITS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (resid_q <= RW'(DEPTH))); // R6
    AST_SPILL_OVER: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SPILL) |-> (resid_q > RW'(DEPTH))); // R6
    AST_FILL_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILL) |-> (resid_q < need_q)); // R7
    AST_RESID_LE_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
        AW'(resid_q) <= alloc_q); // R3
    AST_ERR_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        op_err |-> ($stable(sp_q) && $stable(alloc_q) && $stable(resid_q))); // R5
    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R8
endmodule

// File: rtl/rstk_bank.sv
module rstk_bank #(
    parameter int DEPTH = 128,
    parameter int DW    = 32,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [DW-1:0] wdata,
    input  logic [IW-1:0] ra_idx,
    output logic [DW-1:0] ra_data,
    input  logic [IW-1:0] rb_idx,
    output logic [DW-1:0] rb_data
);
    logic [DW-1:0] slot_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) slot_q[widx] <= wdata;
    end

    assign ra_data = slot_q[ra_idx];
    assign rb_data = slot_q[rb_idx];
endmodule

// File: rtl/rstk_glob.sv
module rstk_glob #(
    parameter int NUM = 64,
    parameter int DW  = 32,
    localparam int GW = $clog2(NUM)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [GW-1:0] widx,
    input  logic [DW-1:0] wdata,
    input  logic [GW-1:0] ridx,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] word_q [NUM];

    for (genvar g = 0; g < NUM; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (we && (widx == GW'(g))) word_q[g] <= wdata;
        end
    end

    assign rdata = word_q[ridx];
endmodule

// File: rtl/regstack_ctrl.sv
module regstack_ctrl #(
    parameter int DEPTH  = 128,
    parameter int GLOB_N = 64,
    parameter int DW     = 32,
    parameter int AW     = 16,
    localparam int IW    = $clog2(DEPTH),
    localparam int GW    = $clog2(GLOB_N),
    localparam int SZW   = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           op_valid,
    input  logic           op_ret,
    input  logic [SZW-1:0] op_size,
    input  logic [SZW-1:0] op_caller,
    output logic           busy,
    output logic           op_err,
    input  logic           rd_glob,
    input  logic [IW-1:0]  rd_idx,
    output logic [DW-1:0]  rd_data,
    input  logic           wr_en,
    input  logic           wr_glob,
    input  logic [IW-1:0]  wr_idx,
    input  logic [DW-1:0]  wr_data,
    output logic           mem_req,
    output logic           mem_we,
    output logic [AW-1:0]  mem_addr,
    output logic [DW-1:0]  mem_wdata,
    input  logic           mem_ack,
    input  logic [DW-1:0]  mem_rdata
);
    logic [IW-1:0] sp_idx, port_idx, bank_widx;
    logic          fill_wr, user_stack_we, user_glob_we, bank_we;
    logic [DW-1:0] bank_wdata, stack_rd, glob_rd;
    logic [DW-1:0] rd_q;

    rstk_ctrl #(.DEPTH(DEPTH), .AW(AW)) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_valid (op_valid),
        .op_ret   (op_ret),
        .op_size  (op_size),
        .op_caller(op_caller),
        .mem_ack  (mem_ack),
        .busy     (busy),
        .op_err   (op_err),
        .sp_idx   (sp_idx),
        .mem_req  (mem_req),
        .mem_we   (mem_we),
        .mem_addr (mem_addr),
        .port_idx (port_idx),
        .fill_wr  (fill_wr)
    );

    always_comb begin
        user_stack_we = wr_en && !wr_glob && !busy;
        user_glob_we  = wr_en && wr_glob && !busy;
        bank_we       = user_stack_we || fill_wr;
        bank_widx     = fill_wr ? port_idx : (sp_idx + wr_idx);
        bank_wdata    = fill_wr ? mem_rdata : wr_data;
    end

    rstk_bank #(.DEPTH(DEPTH), .DW(DW)) bank_i (
        .clk    (clk),
        .we     (bank_we),
        .widx   (bank_widx),
        .wdata  (bank_wdata),
        .ra_idx (sp_idx + rd_idx),
        .ra_data(stack_rd),
        .rb_idx (port_idx),
        .rb_data(mem_wdata)
    );

    rstk_glob #(.NUM(GLOB_N), .DW(DW)) glob_i (
        .clk  (clk),
        .we   (user_glob_we),
        .widx (wr_idx[GW-1:0]),
        .wdata(wr_data),
        .ridx (rd_idx[GW-1:0]),
        .rdata(glob_rd)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_glob ? glob_rd : stack_rd;
    end
    assign rd_data = rd_q;

    AST_NO_WRITE_COLLIDE: assert property (@(posedge clk) disable iff (!rst_n)
        fill_wr |-> !user_stack_we); // R8
endmodule

// File: tb/regstack_ctrl_tb_top.sv
module regstack_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 0, op_ret = 0;
    logic [7:0]  op_size = 0, op_caller = 0;
    logic        busy, op_err;
    logic        rd_glob = 0;
    logic [6:0]  rd_idx = 0;
    logic [31:0] rd_data;
    logic        wr_en = 0, wr_glob = 0;
    logic [6:0]  wr_idx = 0;
    logic [31:0] wr_data = 0;
    logic        mem_req, mem_we;
    logic [15:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ack = 0;
    logic [31:0] mem_rdata = 0;

    logic [31:0] mem [1024];
    int n_wr = 0, n_rd = 0, last_rd_addr = -1;
    int checks = 0, fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    regstack_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ret(op_ret),
        .op_size(op_size), .op_caller(op_caller), .busy(busy), .op_err(op_err),
        .rd_glob(rd_glob), .rd_idx(rd_idx), .rd_data(rd_data),
        .wr_en(wr_en), .wr_glob(wr_glob), .wr_idx(wr_idx), .wr_data(wr_data),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    // memory model: one acknowledge per request, then a quiet cycle
    initial begin
        forever begin
            @(negedge clk);
            if (mem_ack) mem_ack = 1'b0;
            else if (mem_req) begin
                if (mem_we) begin
                    mem[mem_addr[9:0]] = mem_wdata;
                    n_wr++;
                end else begin
                    mem_rdata = mem[mem_addr[9:0]];
                    last_rd_addr = int'(mem_addr);
                    n_rd++;
                end
                mem_ack = 1'b1;
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_op(input bit ret, input int size, input int caller,
                         input bit wait_idle, output bit err);
        while (busy) @(negedge clk);
        op_valid = 1; op_ret = ret; op_size = 8'(size); op_caller = 8'(caller);
        @(negedge clk);
        op_valid = 0;
        err = op_err;
        if (wait_idle) while (busy) @(negedge clk);
    endtask

    task automatic wr(input bit g, input int idx, input logic [31:0] d);
        wr_en = 1; wr_glob = g; wr_idx = 7'(idx); wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd(input bit g, input int idx, output logic [31:0] d);
        rd_glob = g; rd_idx = 7'(idx);
        @(negedge clk);
        d = rd_data;
    endtask

    task automatic t_reset;
        bit e;
        check("R1 busy", 32'(busy), 0);
        check("R1 err", 32'(op_err), 0);
        check("R1 mem_req", 32'(mem_req), 0);
        check("R1 rd_data", rd_data, 0);
        do_op(1, 1, 0, 1, e);
        check("R1 empty return rejected", 32'(e), 1);
    endtask

    task automatic t_glob;
        logic [31:0] d;
        wr(1, 5, 32'hA5A5);
        wr(1, 63, 32'h1234);
        rd(1, 5, d);  check("R2 g5", d, 32'hA5A5);
        rd(1, 63, d); check("R2 g63", d, 32'h1234);
        rd(1, 69, d); check("R2 low six bits", d, 32'hA5A5);
    endtask

    task automatic t_window;
        bit e;
        logic [31:0] d;
        do_op(0, 2, 0, 1, e);
        check("R3 call2 ok", 32'(e), 0);
        wr(0, 0, 32'h100);
        wr(0, 1, 32'h101);
        do_op(0, 3, 0, 1, e);
        wr(0, 0, 32'h300); wr(0, 1, 32'h301); wr(0, 2, 32'h302);
        rd(0, 3, d); check("R3 r3 is old r0", d, 32'h100);
        rd(0, 4, d); check("R3 r4 is old r1", d, 32'h101);
        rd(1, 5, d); check("R2 glob after call", d, 32'hA5A5);
        do_op(1, 3, 2, 1, e);
        check("R4 return ok", 32'(e), 0);
        rd(0, 0, d); check("R4 r0", d, 32'h100);
        rd(0, 1, d); check("R4 r1", d, 32'h101);
        check("R6 no spill", 32'(n_wr), 0);
    endtask

    task automatic t_same;
        bit e;
        logic [31:0] d;
        op_valid = 1; op_ret = 0; op_size = 4; op_caller = 0;
        wr_en = 1; wr_glob = 0; wr_idx = 0; wr_data = 32'h222;
        rd_glob = 0; rd_idx = 1;
        @(negedge clk);
        op_valid = 0; wr_en = 0;
        check("R9 read uses old mapping", rd_data, 32'h101);
        rd(0, 4, d); check("R9 write landed at old r0", d, 32'h222);
        rd(0, 5, d); check("R3 r5 is old r1", d, 32'h101);
        do_op(1, 4, 2, 1, e);
        rd(0, 0, d); check("R4 r0 after same-cycle", d, 32'h222);
    endtask

    task automatic t_err;
        bit e;
        logic [31:0] d;
        do_op(0, 0, 0, 1, e);   check("R5 call0", 32'(e), 1);
        do_op(0, 129, 0, 1, e); check("R5 call129", 32'(e), 1);
        do_op(1, 3, 0, 1, e);   check("R5 return too big", 32'(e), 1);
        do_op(1, 2, 1, 1, e);   check("R5 caller exceeds alloc", 32'(e), 1);
        do_op(1, 1, 200, 1, e); check("R5 caller above 128", 32'(e), 1);
        @(negedge clk);
        check("R5 err one cycle", 32'(op_err), 0);
        rd(0, 0, d); check("R5 r0 kept", d, 32'h222);
        rd(0, 1, d); check("R5 r1 kept", d, 32'h101);
        check("R5 no memory traffic", 32'(n_wr + n_rd), 0);
    endtask

    task automatic t_spill1;
        bit e;
        logic [31:0] d;
        do_op(0, 127, 0, 0, e);
        check("R8 busy during spill", 32'(busy), 1);
        wr(1, 5, 32'hDEAD);
        while (busy) @(negedge clk);
        check("R6 one word spilled", 32'(n_wr), 1);
        check("R6 addr0 holds oldest", mem[0], 32'h101);
        rd(1, 5, d); check("R8 write while busy ignored", d, 32'hA5A5);
        wr(0, 0, 32'h777);
        mem[0] = 32'hBEEF;
        do_op(1, 127, 2, 0, e);
        check("R8 busy during fill", 32'(busy), 1);
        while (busy) @(negedge clk);
        check("R7 one fill", 32'(n_rd), 1);
        check("R7 fill addr", 32'(last_rd_addr), 0);
        rd(0, 1, d); check("R7 r1 from memory", d, 32'hBEEF);
        rd(0, 0, d); check("R7 r0 untouched", d, 32'h222);
    endtask

    task automatic t_spill2;
        bit e;
        logic [31:0] d;
        do_op(0, 128, 0, 0, e);
        op_valid = 1; op_ret = 0; op_size = 5;
        @(negedge clk);
        op_valid = 0;
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
        check("R8 stalled call ignored", 32'(busy), 0);
        check("R6 two more spilled", 32'(n_wr), 3);
        check("R6 addr0 oldest", mem[0], 32'hBEEF);
        check("R6 addr1 next", mem[1], 32'h222);
        mem[0] = 32'h11; mem[1] = 32'h22;
        do_op(1, 128, 2, 1, e);
        check("R7 return ok", 32'(e), 0);
        check("R7 two fills", 32'(n_rd), 3);
        check("R7 last fill addr", 32'(last_rd_addr), 0);
        rd(0, 0, d); check("R7 r0 refilled", d, 32'h22);
        rd(0, 1, d); check("R7 r1 refilled", d, 32'h11);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_glob();
        t_window();
        t_same();
        t_err();
        t_spill1();
        t_spill2();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule